// File: doc/BRIEF.md
# Condition Flag Register and Branch Decision Unit

This block keeps the four arithmetic condition flags of a small 8-bit processor: carry, overflow, negative and zero. It also decides whether a conditional branch is taken. On each enabled clock edge, the execute stage writes any subset of the flags through per-flag enables. Two dedicated commands force the carry flag high or low without touching the other three flags.

The branch decision is combinational by default. It is formed from a 4-bit condition code, the current flags, and two I/O status bits: input buffer holds data, and output buffer is full. The sixteen codes cover:

- unconditional branches;
- single-flag tests in both polarities;
- unsigned-style sign/zero tests;
- signed comparisons derived from overflow XOR negative;
- two tests of I/O buffer status.

Moving the program counter and fetching the target stay with the surrounding sequencer.

Top module: `cond_flag_unit`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears all four flags, whatever the state of `ce_i`.
- R2: While `ce_i` is low, no flag changes, whatever the write enables, values and carry commands.
- R3: The flag vector is ordered as bit 3 carry (C), bit 2 overflow (V), bit 1 negative (N) and bit 0 zero (Z). This order applies to `flags_o`, `upd_en_i` and `upd_val_i`. With `ce_i` high, each flag whose enable bit is set loads its value bit at the edge, and each flag whose enable is clear keeps its value.
- R4: With `ce_i` high, `carry_set_i` forces C to 1, and `carry_clr_i` forces C to 0. V, N and Z are left to their own enables. Priority for C is set, then clear, then the per-flag write.
- R5: Code 0000 is always taken. Code 1000 is taken exactly when V is 1.
- R6: Codes 0001 and 1001 are taken when Z is 0 and 1 respectively. Codes 0010 and 1010 are taken when N is 0 and 1. Codes 0101 and 1101 are taken when C is 0 and 1.
- R7: Code 0011 is taken when N OR Z is 0. Code 1011 is the complement.
- R8: Code 1110 is taken when V XOR N is 1. Code 0110 is the complement.
- R9: Code 1111 is taken when (V XOR N) OR Z is 1. Code 0111 is the complement.
- R10: Code 0100 is taken when `ibuf_valid_i` is 0. Code 1100 is taken when `obuf_full_i` is 1. The two buffer-status inputs have no effect on any other code.
- R11: With the default `TAKEN_REG` of 0, `taken_o` is combinational in `cond_i`, the flags and the buffer status. A flag written at an edge is therefore reflected in `taken_o` right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Clock enable for flag updates |
| upd_en_i | input | 4 | Per-flag write enable {C,V,N,Z} |
| upd_val_i | input | 4 | Per-flag write value {C,V,N,Z} |
| carry_set_i | input | 1 | Force carry to 1 |
| carry_clr_i | input | 1 | Force carry to 0 |
| ibuf_valid_i | input | 1 | Input buffer holds data |
| obuf_full_i | input | 1 | Output buffer is full |
| cond_i | input | 4 | Branch condition code |
| flags_o | output | 4 | Current flags {C,V,N,Z} |
| taken_o | output | 1 | Branch condition satisfied |

## Verification
The assertions take three things for granted:

- the reset input is defined from the first clock edge onward;
- all control inputs are known, never X, at every edge;
- the combinational branch variant is the one elaborated.

The bench holds reset from time zero and drives every input at the falling edge. It returns the enables and carry commands to zero between steps, so only intended writes reach the flag register. It also sets both carry commands together in one step, so the stated priority is observed directly at `flags_o`.

// File: rtl/cfu_pkg.sv
`timescale 1ns/1ps
package cfu_pkg;
   localparam int FLAG_N = 4;
   localparam int C_BIT  = 3;
   localparam int V_BIT  = 2;
   localparam int N_BIT  = 1;
   localparam int Z_BIT  = 0;

   typedef struct packed {
      logic c;
      logic v;
      logic n;
      logic z;
   } flags_t;

   // Low three bits of the condition code pick a test family;
   // the top bit picks the polarity or the alternate member.
   typedef enum logic [2:0] {
      SEL_ALW_V = 3'd0,
      SEL_ZERO  = 3'd1,
      SEL_NEG   = 3'd2,
      SEL_NZ    = 3'd3,
      SEL_IO    = 3'd4,
      SEL_CARRY = 3'd5,
      SEL_SLT   = 3'd6,
      SEL_SLE   = 3'd7
   } csel_e;
endpackage

// File: rtl/cfu_flag_reg.sv
`timescale 1ns/1ps
module cfu_flag_reg #(
   parameter int FLAG_N = cfu_pkg::FLAG_N,
   parameter int C_BIT  = cfu_pkg::C_BIT
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ce_i,
   input  logic [FLAG_N-1:0] upd_en_i,
   input  logic [FLAG_N-1:0] upd_val_i,
   input  logic              carry_set_i,
   input  logic              carry_clr_i,
   output logic [FLAG_N-1:0] flags_o
);
   logic [FLAG_N-1:0] flags_q;
   logic [FLAG_N-1:0] flags_d;

   for (genvar i = 0; i < FLAG_N; i++) begin : g_bit
      if (i == C_BIT) begin : g_carry
         // set beats clear beats the ordinary write
         assign flags_d[i] = carry_set_i ? 1'b1 :
                             carry_clr_i ? 1'b0 :
                             (upd_en_i[i] ? upd_val_i[i] : flags_q[i]);
      end else begin : g_plain
         assign flags_d[i] = upd_en_i[i] ? upd_val_i[i] : flags_q[i];
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)     flags_q <= '0;
      else if (ce_i) flags_q <= flags_d;
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/cfu_cond_eval.sv
`timescale 1ns/1ps
module cfu_cond_eval #(
   parameter int COND_W = 4,
   parameter int FLAG_N = cfu_pkg::FLAG_N
) (
   input  logic [COND_W-1:0] cond_i,
   input  logic [FLAG_N-1:0] flags_i,
   input  logic              ibuf_valid_i,
   input  logic              obuf_full_i,
   output logic              taken_o
);
   import cfu_pkg::*;

   localparam int POL_BIT = COND_W - 1;

   flags_t f;
   csel_e  sel;
   logic   alt;
   logic   s_lt;
   logic   base;

   assign f    = flags_t'(flags_i);
   assign sel  = csel_e'(cond_i[2:0]);
   assign alt  = cond_i[POL_BIT];
   assign s_lt = f.v ^ f.n;

   always_comb begin
      case (sel)
         SEL_ZERO:  base = f.z;
         SEL_NEG:   base = f.n;
         SEL_NZ:    base = f.n | f.z;
         SEL_CARRY: base = f.c;
         SEL_SLT:   base = s_lt;
         SEL_SLE:   base = s_lt | f.z;
         default:   base = 1'b0;
      endcase
   end

   always_comb begin
      case (sel)
         SEL_ALW_V: taken_o = alt ? f.v : 1'b1;
         SEL_IO:    taken_o = alt ? obuf_full_i : ~ibuf_valid_i;
         default:   taken_o = alt ? base : ~base;
      endcase
   end
endmodule

// File: rtl/cond_flag_unit.sv
`timescale 1ns/1ps
module cond_flag_unit #(
   parameter int COND_W    = 4,
   parameter int FLAG_W    = 4,
   parameter int TAKEN_REG = 0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ce_i,
   input  logic [FLAG_W-1:0] upd_en_i,
   input  logic [FLAG_W-1:0] upd_val_i,
   input  logic              carry_set_i,
   input  logic              carry_clr_i,
   input  logic              ibuf_valid_i,
   input  logic              obuf_full_i,
   input  logic [COND_W-1:0] cond_i,
   output logic [FLAG_W-1:0] flags_o,
   output logic              taken_o
);
   if (COND_W != 4) begin : g_bad_cond
      $error("cond_flag_unit: COND_W must be 4");
   end
   if (FLAG_W != cfu_pkg::FLAG_N) begin : g_bad_flag
      $error("cond_flag_unit: FLAG_W must match the package flag count");
   end
   if (TAKEN_REG != 0 && TAKEN_REG != 1) begin : g_bad_treg
      $error("cond_flag_unit: TAKEN_REG must be 0 or 1");
   end

   logic [FLAG_W-1:0] flags_w;
   logic              taken_w;

   cfu_flag_reg #(.FLAG_N(FLAG_W), .C_BIT(cfu_pkg::C_BIT)) flag_reg_i (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .ce_i        (ce_i),
      .upd_en_i    (upd_en_i),
      .upd_val_i   (upd_val_i),
      .carry_set_i (carry_set_i),
      .carry_clr_i (carry_clr_i),
      .flags_o     (flags_w)
   );

   cfu_cond_eval #(.COND_W(COND_W), .FLAG_N(FLAG_W)) cond_eval_i (
      .cond_i       (cond_i),
      .flags_i      (flags_w),
      .ibuf_valid_i (ibuf_valid_i),
      .obuf_full_i  (obuf_full_i),
      .taken_o      (taken_w)
   );

   assign flags_o = flags_w;

   if (TAKEN_REG == 1) begin : g_taken_ff
      logic taken_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) taken_q <= 1'b0;
         else       taken_q <= taken_w;
      end
      assign taken_o = taken_q;
   end else begin : g_taken_comb
      assign taken_o = taken_w;
   end
endmodule

// File: rtl/cfu_checker.sv
`timescale 1ns/1ps
module cfu_checker #(
   parameter int TAKEN_REG = 0
) (
   input logic       clk_i,
   input logic       rst_i,
   input logic       ce_i,
   input logic [3:0] upd_en_i,
   input logic       carry_set_i,
   input logic       carry_clr_i,
   input logic       ibuf_valid_i,
   input logic [3:0] cond_i,
   input logic [3:0] flags_o,
   input logic       taken_o
);
   a_r1_reset_clears: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> (flags_o == 4'b0000));

   a_r2_hold_no_ce: assert property (@(posedge clk_i) disable iff (rst_i)
      !ce_i |=> $stable(flags_o));

   a_r3_no_write_no_change: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && !carry_set_i && !carry_clr_i && upd_en_i == 4'b0000) |=> $stable(flags_o));

   a_r4_set_carry: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && carry_set_i) |=> flags_o[3]);

   a_r4_clr_carry: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && !carry_set_i && carry_clr_i) |=> !flags_o[3]);

   a_r4_others_kept: assert property (@(posedge clk_i) disable iff (rst_i)
      (ce_i && (carry_set_i || carry_clr_i) && upd_en_i[2:0] == 3'b000)
      |=> $stable(flags_o[2:0]));

   if (TAKEN_REG == 0) begin : g_comb_checks
      a_r5_always: assert property (@(posedge clk_i) disable iff (rst_i)
         (cond_i == 4'b0000) |-> taken_o);

      a_r8_signed_lt: assert property (@(posedge clk_i) disable iff (rst_i)
         (cond_i == 4'b1110) |-> (taken_o == (flags_o[2] ^ flags_o[1])));

      a_r10_no_input: assert property (@(posedge clk_i) disable iff (rst_i)
         (cond_i == 4'b0100) |-> (taken_o == !ibuf_valid_i));
   end
endmodule

bind cond_flag_unit cfu_checker #(.TAKEN_REG(TAKEN_REG)) chk_i (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .ce_i         (ce_i),
   .upd_en_i     (upd_en_i),
   .carry_set_i  (carry_set_i),
   .carry_clr_i  (carry_clr_i),
   .ibuf_valid_i (ibuf_valid_i),
   .cond_i       (cond_i),
   .flags_o      (flags_o),
   .taken_o      (taken_o)
);

// File: tb/cond_flag_unit_tb_top.sv
`timescale 1ns/1ps
module cond_flag_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ce = 1'b0;
   logic [3:0] en = '0;
   logic [3:0] val = '0;
   logic       cset = 1'b0;
   logic       cclr = 1'b0;
   logic       ivalid = 1'b0;
   logic       ofull = 1'b0;
   logic [3:0] cond = '0;
   logic [3:0] flags;
   logic       taken;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cond_flag_unit dut_i (
      .clk_i(clk), .rst_i(rst), .ce_i(ce), .upd_en_i(en), .upd_val_i(val),
      .carry_set_i(cset), .carry_clr_i(cclr), .ibuf_valid_i(ivalid),
      .obuf_full_i(ofull), .cond_i(cond), .flags_o(flags), .taken_o(taken)
   );

   // {ce, set, clr, en[3:0], val[3:0], expected flags[3:0]}
   localparam int NV = 10;
   localparam logic [14:0] VEC [NV] = '{
      {3'b100, 4'b1111, 4'b0010, 4'b0010},
      {3'b110, 4'b0000, 4'b0000, 4'b1010},
      {3'b001, 4'b1111, 4'b0101, 4'b1010},
      {3'b101, 4'b0000, 4'b0000, 4'b0010},
      {3'b100, 4'b0101, 4'b1111, 4'b0111},
      {3'b111, 4'b1000, 4'b0000, 4'b1111},
      {3'b101, 4'b1000, 4'b1000, 4'b0111},
      {3'b100, 4'b1000, 4'b1000, 4'b1111},
      {3'b100, 4'b0110, 4'b0000, 4'b1001},
      {3'b100, 4'b0000, 4'b0000, 4'b1001}
   };

   function automatic logic ref_taken(input logic [3:0] c, input logic [3:0] f,
                                      input logic iv, input logic of);
      logic fc, fv, fn, fz;
      fc = f[3]; fv = f[2]; fn = f[1]; fz = f[0];
      case (c)
         4'b0000: return 1'b1;                  // R5
         4'b1000: return fv;                    // R5
         4'b0001: return !fz;                   // R6
         4'b1001: return fz;                    // R6
         4'b0010: return !fn;                   // R6
         4'b1010: return fn;                    // R6
         4'b0101: return !fc;                   // R6
         4'b1101: return fc;                    // R6
         4'b0011: return !(fn || fz);           // R7
         4'b1011: return fn || fz;              // R7
         4'b1110: return fv != fn;              // R8
         4'b0110: return fv == fn;              // R8
         4'b1111: return (fv != fn) || fz;      // R9
         4'b0111: return !((fv != fn) || fz);   // R9
         4'b0100: return !iv;                   // R10
         default: return of;                    // 1100, R10
      endcase
   endfunction

   task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, got, exp);
      end
   endtask

   task automatic step(input logic c_e, input logic s, input logic r,
                       input logic [3:0] e, input logic [3:0] v);
      @(negedge clk);
      ce = c_e; cset = s; cclr = r; en = e; val = v;
      @(posedge clk);
      #1;
      ce = 1'b0; cset = 1'b0; cclr = 1'b0; en = '0; val = '0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state, R5 always-taken code out of reset
      check("R1", flags, 4'b0000);
      cond = 4'b0000; #1;
      check("R5", {3'b000, taken}, 4'b0001);

      // table walk: R2/R3/R4 flag writes, R11 taken follows new flags
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = !VEC[i][14] ? "R2" : (VEC[i][13] || VEC[i][12]) ? "R4" : "R3";
         step(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7:4]);
         check(tag, flags, VEC[i][3:0]);
         cond = 4'b1101; #1;
         check("R11", {3'b000, taken}, {3'b000, VEC[i][3]});
      end

      // exhaustive condition decode: R5..R10
      for (int f = 0; f < 16; f++) begin
         step(1'b1, 1'b0, 1'b0, 4'b1111, f[3:0]);
         check("R3", flags, f[3:0]);
         for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 16; c++) begin
               string tag;
               ivalid = b[0]; ofull = b[1]; cond = c[3:0];
               #1;
               case (c[2:0])
                  3'd0: tag = "R5";
                  3'd1, 3'd2, 3'd5: tag = "R6";
                  3'd3: tag = "R7";
                  3'd4: tag = "R10";
                  3'd6: tag = "R8";
                  default: tag = "R9";
               endcase
               check(tag, {3'b000, taken},
                     {3'b000, ref_taken(c[3:0], f[3:0], b[0], b[1])});
            end
         end
      end

      // R1: reset with ce low clears flags from all-ones
      step(1'b1, 1'b0, 1'b0, 4'b1111, 4'b1111);
      check("R3", flags, 4'b1111);
      @(negedge clk);
      rst = 1'b1; ce = 1'b0;
      @(posedge clk); #1;
      check("R1", flags, 4'b0000);
      @(negedge clk);
      rst = 1'b0;
      // R2: carry command ignored with ce low
      step(1'b0, 1'b1, 1'b0, 4'b1111, 4'b1111);
      check("R2", flags, 4'b0000);
      finish_run();
   end
endmodule